// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block watches over running software. Software sets it going through one control write that carries an arm bit and a small key. From then on the block counts clock cycles. If software does not service it before a first limit is reached, the block raises a non-maskable interrupt. If software still does nothing during a second, shorter window, the block raises a chip reset request. The request is held for a fixed number of cycles, and the watchdog then returns to its stopped state.

Servicing is protected by a key. A write is accepted as a restart or a stop only when its key field is the bitwise inverse of the key the block currently holds. A restart also stores the written key, so the next service has to invert it again. A write whose key is anything else does not touch the count. It only replaces the stored key. Both timeouts and the reset pulse width are parameters given in cycles, so the same block works at any clock rate. A status readback shows whether the watchdog is running and which key it holds.

Top module: `keyed_watchdog`

## Requirements
- R1: While rst_n is low, and right after it is released, the watchdog is stopped: nmi_o=0, chip_rst_o=0, sts_running=0 and sts_key=0.
- R2: While stopped, a write with wr_arm=0 has no effect: the watchdog stays stopped and sts_key keeps its value.
- R3: While stopped, a write with wr_arm=1 starts the watchdog. From the cycle after the write edge, sts_running=1 and sts_key equals the written wr_key.
- R4: With no accepted service, nmi_o rises exactly FIRST_CYC clock edges after the edge that started or restarted the count.
- R5: With no accepted service, chip_rst_o rises exactly SECOND_CYC edges after nmi_o rose. nmi_o falls at the same edge. chip_rst_o then stays high for PULSE_CYC edges, after which the watchdog is stopped.
- R6: While running, a write with wr_arm=1 and wr_key equal to the bitwise inverse of sts_key restarts the first timeout and stores wr_key.
- R7: While running, a write with wr_arm=0 and wr_key equal to the bitwise inverse of sts_key stops the watchdog and leaves sts_key unchanged.
- R8: While running, a write whose wr_key is not the bitwise inverse of sts_key stores wr_key, whatever wr_arm is, and does not restart or stop the count.
- R9: An accepted restart or stop while nmi_o is high clears nmi_o at that edge, and no reset follows from the cancelled stage.
- R10: While chip_rst_o is high, writes are ignored: the stored key, the pulse length and the return to the stopped state do not change.
- R11: nmi_o and chip_rst_o are never high in the same cycle, and sts_running is low whenever chip_rst_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_arm | input | 1 | Arm bit of the control write |
| wr_key | input | KEY_W | Key field of the control write |
| sts_running | output | 1 | Watchdog is counting, in the first or the NMI stage |
| sts_key | output | KEY_W | Currently stored key |
| nmi_o | output | 1 | Non-maskable interrupt, high during the second stage |
| chip_rst_o | output | 1 | Chip reset request, high for PULSE_CYC cycles |

## Verification
The embedded assertions check on every cycle the rules that hold edge to edge. A stopped block ignores a disarmed write. A start stores the key. A wrong key always replaces the stored one. A service during the NMI stage drops the interrupt. Writes during the reset pulse cannot revive the counter. The interrupt and the reset are never high together. The exact lengths of the two timeouts and the pulse, and the fact that a mismatching write leaves the count running, can only be shown by the bench's scenarios. There a countdown model is compared against the ports every cycle, and explicit checks sample the outputs at the expected edges.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_ALARM = 2'd2,
    ST_PULSE = 2'd3
  } kwd_state_e;
endpackage

// File: rtl/kwd_keyctl.sv
module kwd_keyctl
  import kwd_pkg::*;
#(
  parameter int KEY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  kwd_state_e       state,
  input  logic             wr_en,
  input  logic             wr_arm,
  input  logic [KEY_W-1:0] wr_key,
  output logic             cmd_start,
  output logic             cmd_restart,
  output logic             cmd_stop,
  output logic [KEY_W-1:0] key_q
);
  logic             running;
  logic             key_match;
  logic             key_load;
  logic [KEY_W-1:0] key_d;

  assign running   = (state == ST_COUNT) || (state == ST_ALARM);
  assign key_match = (wr_key == ~key_q);

  always_comb begin
    cmd_start   = 1'b0;
    cmd_restart = 1'b0;
    cmd_stop    = 1'b0;
    key_load    = 1'b0;
    if (wr_en) begin
      if (state == ST_IDLE) begin
        cmd_start = wr_arm;
        key_load  = wr_arm;
      end else if (running) begin
        if (key_match) begin
          cmd_restart = wr_arm;
          cmd_stop    = !wr_arm;
          key_load    = wr_arm;
        end else begin
          key_load = 1'b1;
        end
      end
    end
  end

  always_comb begin
    key_d = key_q;
    if (key_load) key_d = wr_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        key_q <= '0;
    else if (key_load) key_q <= key_d;
  end

  AST_WRONG_KEY_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_en && (wr_key != ~key_q)) |=> (key_q == $past(wr_key))) else $error("wrong key not stored"); // R8

  AST_STOP_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_en && !wr_arm && (wr_key == ~key_q)) |=> $stable(key_q)) else $error("stop changed key"); // R7

  AST_PULSE_KEY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PULSE) |=> $stable(key_q)) else $error("key changed in pulse"); // R10
endmodule

// File: rtl/kwd_timer.sv
module kwd_timer
  import kwd_pkg::*;
#(
  parameter int FIRST_CYC  = 40,
  parameter int SECOND_CYC = 12,
  parameter int PULSE_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  kwd_state_e state,
  input  logic       clr,
  input  logic       run,
  output logic       expired
);
  localparam int MAX_A = (FIRST_CYC > SECOND_CYC) ? FIRST_CYC : SECOND_CYC;
  localparam int MAX_L = (MAX_A > PULSE_CYC) ? MAX_A : PULSE_CYC;
  localparam int CW    = $clog2(MAX_L + 1);
  localparam logic [CW-1:0] LIM_FIRST  = CW'(FIRST_CYC - 1);
  localparam logic [CW-1:0] LIM_SECOND = CW'(SECOND_CYC - 1);
  localparam logic [CW-1:0] LIM_PULSE  = CW'(PULSE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] limit;

  always_comb begin
    unique case (state)
      ST_COUNT: limit = LIM_FIRST;
      ST_ALARM: limit = LIM_SECOND;
      ST_PULSE: limit = LIM_PULSE;
      default:  limit = '1;
    endcase
  end

  assign expired = (state != ST_IDLE) && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || run) cnt_q <= cnt_d;
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (cnt_q <= limit)) else $error("counter passed limit"); // R4
endmodule

// File: rtl/kwd_fsm.sv
module kwd_fsm
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_arm,
  input  logic       cmd_start,
  input  logic       cmd_restart,
  input  logic       cmd_stop,
  input  logic       expired,
  output kwd_state_e state,
  output logic       cnt_clr,
  output logic       cnt_run,
  output logic       nmi,
  output logic       rst_req,
  output logic       running
);
  kwd_state_e state_d;

  always_comb begin
    state_d = state;
    cnt_clr = 1'b0;
    cnt_run = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmd_start) begin
          state_d = ST_COUNT;
          cnt_clr = 1'b1;
        end
      end
      ST_COUNT, ST_ALARM: begin
        if (cmd_restart) begin
          state_d = ST_COUNT;
          cnt_clr = 1'b1;
        end else if (cmd_stop) begin
          state_d = ST_IDLE;
          cnt_clr = 1'b1;
        end else if (expired) begin
          state_d = (state == ST_COUNT) ? ST_ALARM : ST_PULSE;
          cnt_clr = 1'b1;
        end else begin
          cnt_run = 1'b1;
        end
      end
      ST_PULSE: begin
        if (expired) begin
          state_d = ST_IDLE;
          cnt_clr = 1'b1;
        end else begin
          cnt_run = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  assign nmi     = (state == ST_ALARM);
  assign rst_req = (state == ST_PULSE);
  assign running = (state == ST_COUNT) || (state == ST_ALARM);

  AST_NMI_RST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi && rst_req) && !(running && rst_req)) else $error("nmi and reset overlap"); // R11

  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && wr_en && !wr_arm) |=> (state == ST_IDLE)) else $error("disarmed write woke block"); // R2

  AST_ARMED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && wr_en && wr_arm) |=> running) else $error("start not taken"); // R3

  AST_SERVICE_DROPS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && (cmd_restart || cmd_stop)) |=> !nmi && !rst_req) else $error("service kept nmi"); // R9

  AST_PULSE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (state == ST_IDLE)) else $error("pulse did not end stopped"); // R5

  AST_PULSE_NO_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !running) else $error("write revived counter in pulse"); // R10
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int KEY_W      = 3,
  parameter int FIRST_CYC  = 40,
  parameter int SECOND_CYC = 12,
  parameter int PULSE_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_arm,
  input  logic [KEY_W-1:0] wr_key,
  output logic             sts_running,
  output logic [KEY_W-1:0] sts_key,
  output logic             nmi_o,
  output logic             chip_rst_o
);
  kwd_state_e state;
  logic       cmd_start;
  logic       cmd_restart;
  logic       cmd_stop;
  logic       expired;
  logic       cnt_clr;
  logic       cnt_run;

  kwd_keyctl #(.KEY_W(KEY_W)) u_keyctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .wr_en       (wr_en),
    .wr_arm      (wr_arm),
    .wr_key      (wr_key),
    .cmd_start   (cmd_start),
    .cmd_restart (cmd_restart),
    .cmd_stop    (cmd_stop),
    .key_q       (sts_key)
  );

  kwd_timer #(
    .FIRST_CYC  (FIRST_CYC),
    .SECOND_CYC (SECOND_CYC),
    .PULSE_CYC  (PULSE_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .clr     (cnt_clr),
    .run     (cnt_run),
    .expired (expired)
  );

  kwd_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_arm      (wr_arm),
    .cmd_start   (cmd_start),
    .cmd_restart (cmd_restart),
    .cmd_stop    (cmd_stop),
    .expired     (expired),
    .state       (state),
    .cnt_clr     (cnt_clr),
    .cnt_run     (cnt_run),
    .nmi         (nmi_o),
    .rst_req     (chip_rst_o),
    .running     (sts_running)
  );
endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  localparam int KW  = 3;
  localparam int T1  = 40;
  localparam int T2  = 12;
  localparam int TP  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_arm = 1'b0;
  logic [KW-1:0] wr_key = '0;
  logic          sts_running;
  logic [KW-1:0] sts_key;
  logic          nmi_o;
  logic          chip_rst_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // behavioural model: 0 stopped, 1 first stage, 2 nmi stage, 3 reset pulse
  int m_stage = 0;
  int m_left  = 0;
  int m_key   = 0;

  always #4 clk = ~clk;

  keyed_watchdog #(.KEY_W(KW), .FIRST_CYC(T1), .SECOND_CYC(T2), .PULSE_CYC(TP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_arm(wr_arm), .wr_key(wr_key),
    .sts_running(sts_running), .sts_key(sts_key), .nmi_o(nmi_o), .chip_rst_o(chip_rst_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage <= 0; m_left <= 0; m_key <= 0;
    end else begin
      int inv;
      inv = (~m_key) & ((1 << KW) - 1);
      if (m_stage == 0) begin
        if (wr_en && wr_arm) begin m_stage <= 1; m_left <= T1; m_key <= wr_key; end
      end else if (m_stage == 3) begin
        if (m_left == 1) m_stage <= 0; else m_left <= m_left - 1;
      end else begin
        if (wr_en && int'(wr_key) == inv && wr_arm) begin
          m_stage <= 1; m_left <= T1; m_key <= wr_key;
        end else if (wr_en && int'(wr_key) == inv) begin
          m_stage <= 0;
        end else begin
          if (wr_en) m_key <= wr_key;
          if (m_left == 1) begin
            m_stage <= m_stage + 1;
            m_left  <= (m_stage == 1) ? T2 : TP;
          end else m_left <= m_left - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 model nmi", int'(nmi_o), int'(m_stage == 2));
      check("R5 model reset", int'(chip_rst_o), int'(m_stage == 3));
      check("R3 model running", int'(sts_running), int'(m_stage == 1 || m_stage == 2));
      check("R8 model key", int'(sts_key), m_key);
      check("R11 exclusive", int'(nmi_o && chip_rst_o), 0);
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      report();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_write(input logic arm, input logic [KW-1:0] key);
    wr_en = 1'b1; wr_arm = arm; wr_key = key;
    @(negedge clk);
    #1;
    wr_en = 1'b0; wr_arm = 1'b0; wr_key = '0;
  endtask

  initial begin
    step(3);
    check("R1 nmi in reset", int'(nmi_o), 0);
    check("R1 reset out in reset", int'(chip_rst_o), 0);
    rst_n = 1'b1;
    step(1);
    check("R1 running after reset", int'(sts_running), 0);
    check("R1 key after reset", int'(sts_key), 0);

    do_write(1'b0, 3'd5);
    step(2);
    check("R2 disarmed write ignored", int'(sts_running), 0);
    check("R2 key unchanged", int'(sts_key), 0);

    do_write(1'b1, 3'd3);
    check("R3 started", int'(sts_running), 1);
    check("R3 key stored", int'(sts_key), 3);
    step(10);
    do_write(1'b1, 3'd6);                       // not ~3
    check("R8 wrong key replaces", int'(sts_key), 6);
    step(T1 - 12);
    check("R8 count not restarted, nmi low", int'(nmi_o), 0);
    step(1);
    check("R4 nmi on time", int'(nmi_o), 1);

    do_write(1'b1, 3'd1);                       // ~6
    check("R9 nmi cleared", int'(nmi_o), 0);
    check("R6 new key stored", int'(sts_key), 1);
    step(T1 - 1);
    check("R9 no reset after cancel", int'(chip_rst_o), 0);
    check("R6 count restarted", int'(nmi_o), 0);
    do_write(1'b1, 3'd6);                       // ~1
    step(T1 - 1);
    check("R6 second restart", int'(nmi_o), 0);
    do_write(1'b0, 3'd1);                       // ~6, stop
    check("R7 stopped", int'(sts_running), 0);
    check("R7 key kept", int'(sts_key), 6);
    step(T1 + 5);
    check("R7 no nmi after stop", int'(nmi_o), 0);

    do_write(1'b1, 3'd2);
    step(T1);
    check("R4 nmi after start", int'(nmi_o), 1);
    step(T2 - 1);
    check("R5 reset not early", int'(chip_rst_o), 0);
    step(1);
    check("R5 reset on time", int'(chip_rst_o), 1);
    check("R5 nmi falls", int'(nmi_o), 0);
    do_write(1'b1, 3'd5);                       // ~2 during pulse
    check("R10 pulse continues", int'(chip_rst_o), 1);
    check("R10 key frozen", int'(sts_key), 2);
    step(TP - 2);
    check("R10 pulse length kept", int'(chip_rst_o), 1);
    step(1);
    check("R5 pulse ended", int'(chip_rst_o), 0);
    check("R5 stopped after pulse", int'(sts_running), 0);
    step(T1 + 2);
    check("R10 no revived count", int'(nmi_o), 0);

    report();
  end
endmodule